// File: doc/BRIEF.md
# Synchronous ROM Burst Read Pipeline

This block is the read data path of a synchronous mask-programmed ROM. A command decoder in front of it passes row-activate strobes carrying a row address, and read strobes carrying a column address. It also passes the programmed mode fields: the CAS latency, the burst length and the burst order. The block turns each read into a burst of column addresses in the requested order. It fetches each word from an internal ROM whose contents are a constant function of the address. Each word reaches a registered 32-bit output after the programmed latency. The output carries a valid flag and an output-enable flag that stands in for the pad tri-state.

While a burst is in flight, the block handles four events: a data mask that acts two clocks after it is sampled, a burst stop, a new read that takes over from the running burst, and a clock-enable input that freezes the whole pipeline. A word-width pin is sampled with each read. It selects either full 32-bit words or 16-bit halves presented on the low output lane.

Top module: `srom_burst_rd`

## Requirements
- R1: A read accepted at an enabled edge t puts burst word 0 on `dout` after enabled edge t+CL, and word k after edge t+CL+k. CL is `cas_lat`, which takes the values 3 to 6 and is held steady while a burst is in flight.
- R2: With `burst_ilv`=0 the column offset counts upward from the start offset and wraps inside the aligned block. The block is 4 words when `burst8`=0 and 8 words when `burst8`=1.
- R3: With `burst_ilv`=1, word k uses the column offset equal to the start offset XOR k.
- R4: The start offset is `rd_col[1:0]` for a burst of 4 and `rd_col[2:0]` for a burst of 8. All higher column bits stay fixed for the whole burst. The burst length and order are taken from the read's own cycle.
- R5: The ROM word at row r and column c is ((r*256 + c[7:0]) * 32'h9E3779B1) XOR 32'h5A5A0000, truncated to 32 bits. The row is the one from the last accepted activate.
- R6: With `word_x32`=1, `dout` carries the full word. With `word_x32`=0, `dout[15:0]` carries bits 15:0 of the word when column bit 8 is 0, and bits 31:16 when it is 1; `dout[31:16]` is zero.
- R7: `word_x32` is sampled only in the read's cycle. Changing it later has no effect on that burst.
- R8: `dqm` high at an enabled edge t drives `dout_oe` low after enabled edge t+2 for that one cycle only, and leaves `dout_vld` unchanged. `dout_oe` is never high without `dout_vld`.
- R9: A stop accepted at enabled edge s, with no read in the same cycle, lets words fetched before s still appear through edge s+CL-1. From edge s+CL onward, `dout_vld` and `dout_oe` are low.
- R10: A read accepted during a burst ends the old burst. The new burst's word 0 follows CL edges later, directly after the old words already in flight, with no gap.
- R11: After the last word of a burst, `dout_vld` and `dout_oe` fall unless a later read continues the stream.
- R12: `cke` low sampled at an edge stops every following edge until an edge where the previous `cke` was high. While stopped, the outputs, the burst position and the mask timing hold, and commands and `dqm` are ignored.
- R13: While `rst_n` is low, `dout` is zero and `dout_vld` and `dout_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the following edges |
| act_en | input | 1 | Row-activate strobe |
| act_row | input | 13 | Row address of the activate |
| rd_en | input | 1 | Read strobe |
| rd_col | input | 9 | Column address of the read |
| word_x32 | input | 1 | 1 = 32-bit words, 0 = 16-bit halves |
| stop_en | input | 1 | Burst-stop strobe |
| dqm | input | 1 | Output mask, acts two enabled edges later |
| cas_lat | input | 3 | CAS latency, 3 to 6 |
| burst8 | input | 1 | 0 = burst of 4, 1 = burst of 8 |
| burst_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| dout | output | 32 | Output word |
| dout_vld | output | 1 | A burst word is on `dout` |
| dout_oe | output | 1 | Output driven (valid and not masked) |

## Verification
All timing is counted in enabled edges, because a frozen edge delays every result. Word k of a read is due CL+k enabled edges after the read, a mask is due 2 after `dqm`, and a stop takes effect CL after it. The bench numbers only the enabled edges and writes each expected word, mask and stop cut into a ring indexed by that number when the command is issued. At each falling edge it compares the outputs with the slot for the current number, or, after a frozen edge, with the values seen one cycle earlier.

// File: rtl/srom_rd_pkg.sv
package srom_rd_pkg;

    localparam int ROW_W  = 13;
    localparam int COL_W  = 9;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int OFS_W  = 3;

    typedef logic [ROW_W-1:0] row_t;
    typedef logic [COL_W-1:0] col_t;

    // One burst beat travelling down the latency line.
    typedef struct packed {
        logic vld;
        logic x32;
        row_t row;
        col_t col;
    } beat_t;

    // Column address of beat k of a burst.
    function automatic col_t burst_col(col_t col, logic bl8, logic ilv, logic [OFS_W-1:0] k);
        logic [OFS_W-1:0] msk;
        logic [OFS_W-1:0] st;
        logic [OFS_W-1:0] ofs;
        msk = bl8 ? 3'b111 : 3'b011;
        st  = col[OFS_W-1:0] & msk;
        ofs = ilv ? (st ^ k) : (st + k);
        return {col[COL_W-1:OFS_W], (col[OFS_W-1:0] & ~msk) | (ofs & msk)};
    endfunction

    // ROM contents: constant function of {row, column[7:0]}.
    function automatic logic [DATA_W-1:0] rom_word(row_t row, logic [COL_W-2:0] col,
                                                  logic [DATA_W-1:0] mult,
                                                  logic [DATA_W-1:0] seed);
        logic [DATA_W-1:0] a;
        a = DATA_W'({row, col});
        return (a * mult) ^ seed;
    endfunction

endpackage

// File: rtl/srom_burst_gen.sv
module srom_burst_gen
    import srom_rd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic act_en,
    input  row_t act_row,
    input  logic rd_en,
    input  col_t rd_col,
    input  logic rd_x32,
    input  logic stop_en,
    input  logic bl8,
    input  logic ilv,
    output beat_t beat
);

    typedef struct packed {
        logic             busy;
        logic [OFS_W-1:0] k;
        logic             bl8;
        logic             ilv;
        logic             x32;
        row_t             arow;
        row_t             brow;
        col_t             bcol;
    } gen_t;

    gen_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        beat = '0;
        if (run) begin
            if (act_en) s_d.arow = act_row;
            if (rd_en) begin
                beat.vld = 1'b1;
                beat.x32 = rd_x32;
                beat.row = s_q.arow;
                beat.col = burst_col(rd_col, bl8, ilv, '0);
                s_d.busy = 1'b1;
                s_d.k    = 3'd1;
                s_d.bl8  = bl8;
                s_d.ilv  = ilv;
                s_d.x32  = rd_x32;
                s_d.brow = s_q.arow;
                s_d.bcol = rd_col;
            end else if (stop_en) begin
                s_d.busy = 1'b0;
            end else if (s_q.busy) begin
                beat.vld = 1'b1;
                beat.x32 = s_q.x32;
                beat.row = s_q.brow;
                beat.col = burst_col(s_q.bcol, s_q.bl8, s_q.ilv, s_q.k);
                s_d.k    = s_q.k + 3'd1;
                s_d.busy = (s_q.k != (s_q.bl8 ? 3'd7 : 3'd3));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/srom_lat_line.sv
module srom_lat_line
    import srom_rd_pkg::*;
#(
    parameter int MAX_CL = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  beat_t      beat_in,
    input  logic [2:0] cas_lat,
    output beat_t      beat_out
);

    beat_t taps [MAX_CL];

    for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
        beat_t src, st_d, st_q;
        if (g == 0) begin : g_head
            assign src = beat_in;
        end else begin : g_body
            assign src = taps[g-1];
        end
        always_comb st_d = run ? src : st_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign taps[g] = st_q;
    end

    // Stage CL (1-based) feeds the output register, giving CL edges in total.
    always_comb begin
        beat_out = '0;
        for (int i = 0; i < MAX_CL; i++) begin
            if (i + 1 == int'(cas_lat)) beat_out = taps[i];
        end
    end

endmodule

// File: rtl/srom_out_stage.sv
module srom_out_stage
    import srom_rd_pkg::*;
#(
    parameter logic [DATA_W-1:0] ROM_MULT = 32'h9E37_79B1,
    parameter logic [DATA_W-1:0] ROM_SEED = 32'h5A5A_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              dqm,
    input  beat_t             beat_in,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              dout_oe
);

    typedef struct packed {
        logic              m1;
        logic              m2;
        logic [DATA_W-1:0] data;
        logic              vld;
        logic              oe;
    } out_t;

    out_t o_d, o_q;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] shaped;

    always_comb begin
        word = rom_word(beat_in.row, beat_in.col[COL_W-2:0], ROM_MULT, ROM_SEED);
        if (beat_in.x32)               shaped = word;
        else if (beat_in.col[COL_W-1]) shaped = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
        else                           shaped = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
    end

    always_comb begin
        o_d = o_q;
        if (run) begin
            o_d.m1   = dqm;
            o_d.m2   = o_q.m1;
            o_d.vld  = beat_in.vld;
            o_d.oe   = beat_in.vld & ~o_q.m2;
            o_d.data = beat_in.vld ? shaped : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dout     = o_q.data;
    assign dout_vld = o_q.vld;
    assign dout_oe  = o_q.oe;

endmodule

// File: rtl/srom_burst_rd.sv
module srom_burst_rd
    import srom_rd_pkg::*;
#(
    parameter int                MAX_CL   = 6,
    parameter logic [DATA_W-1:0] ROM_MULT = 32'h9E37_79B1,
    parameter logic [DATA_W-1:0] ROM_SEED = 32'h5A5A_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              act_en,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              rd_en,
    input  logic [COL_W-1:0]  rd_col,
    input  logic              word_x32,
    input  logic              stop_en,
    input  logic              dqm,
    input  logic [2:0]        cas_lat,
    input  logic              burst8,
    input  logic              burst_ilv,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              dout_oe
);

    // Internal clock gate: an edge acts only if cke was high one edge earlier.
    logic run_d, run_q;

    always_comb run_d = cke;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b1;
        else        run_q <= run_d;
    end

    beat_t gen_beat;
    beat_t lat_beat;

    srom_burst_gen u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .act_en  (act_en),
        .act_row (act_row),
        .rd_en   (rd_en),
        .rd_col  (rd_col),
        .rd_x32  (word_x32),
        .stop_en (stop_en),
        .bl8     (burst8),
        .ilv     (burst_ilv),
        .beat    (gen_beat)
    );

    srom_lat_line #(.MAX_CL(MAX_CL)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .beat_in  (gen_beat),
        .cas_lat  (cas_lat),
        .beat_out (lat_beat)
    );

    srom_out_stage #(.ROM_MULT(ROM_MULT), .ROM_SEED(ROM_SEED)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .dqm      (dqm),
        .beat_in  (lat_beat),
        .dout     (dout),
        .dout_vld (dout_vld),
        .dout_oe  (dout_oe)
    );

endmodule

// File: rtl/srom_burst_rd_chk.sv
module srom_burst_rd_chk #(
    parameter int MAX_CL = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        run_q,
    input logic        rd_en,
    input logic        stop_en,
    input logic        dqm,
    input logic [2:0]  cas_lat,
    input logic [31:0] dout,
    input logic        dout_vld,
    input logic        dout_oe
);

    logic [4:0] idle_q;
    logic [3:0] stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= 5'd31;
            stop_q <= 4'd0;
        end else if (run_q) begin
            idle_q <= rd_en ? 5'd0 : ((idle_q == 5'd31) ? idle_q : idle_q + 5'd1);
            if (rd_en)                              stop_q <= 4'd0;
            else if (stop_en)                       stop_q <= 4'd1;
            else if (stop_q != 0 && stop_q != 4'd15) stop_q <= stop_q + 4'd1;
        end
    end

    // R8: enable only with a valid word
    p_oe_with_vld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> dout_vld);

    // R8: mask lands two enabled edges after dqm
    p_mask_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dqm, 2) && $past(run_q, 2) && $past(run_q, 1) && run_q) |=> !dout_oe);

    // R12: frozen edge changes no output
    p_freeze_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> ($stable(dout) && $stable(dout_vld) && $stable(dout_oe)));

    // R9: stop cuts the stream after CL enabled edges
    p_stop_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q > 4'(cas_lat)) |-> !dout_vld);

    // R11: no valid word long after the last read
    p_burst_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q > 5'(MAX_CL + 7)) |-> !dout_vld);

endmodule

bind srom_burst_rd srom_burst_rd_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_q    (run_q),
    .rd_en    (rd_en),
    .stop_en  (stop_en),
    .dqm      (dqm),
    .cas_lat  (cas_lat),
    .dout     (dout),
    .dout_vld (dout_vld),
    .dout_oe  (dout_oe)
);

// File: tb/sim_srom_burst_rd.sv
module sim_srom_burst_rd;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, cke = 1'b1, act_en = 1'b0, rd_en = 1'b0, word_x32 = 1'b1;
    logic        stop_en = 1'b0, dqm = 1'b0, burst8 = 1'b0, burst_ilv = 1'b0;
    logic [12:0] act_row = '0;
    logic [8:0]  rd_col = '0;
    logic [2:0]  cas_lat = 3'd3;
    logic [31:0] dout;
    logic        dout_vld, dout_oe;

    srom_burst_rd u0 (.*);

    int    n_tot = 0, n_bad = 0;
    string tag = "R13";

    logic        sv [64];
    logic        sm [64];
    logic [31:0] sd [64];
    int          tk = 0;
    logic        ck_prev = 1'b1, last_run = 1'b1;
    logic [12:0] mrow = '0;
    logic [31:0] p_dout = '0;
    logic        p_vld = 1'b0, p_oe = 1'b0;

    function automatic logic [31:0] exp_word(logic [12:0] row, logic [8:0] col, logic x32);
        logic [31:0] a, w;
        a = {11'd0, row, col[7:0]};
        w = (a * 32'h9E3779B1) ^ 32'h5A5A0000;
        if (x32)    return w;
        if (col[8]) return {16'd0, w[31:16]};
        return {16'd0, w[15:0]};
    endfunction

    function automatic logic [8:0] exp_col(logic [8:0] c, logic b8, logic il, int k);
        int n, s, base, idx;
        n    = b8 ? 8 : 4;
        s    = int'(c) % n;
        base = int'(c) - s;
        idx  = il ? (s ^ k) : ((s + k) % n);
        return 9'(base + idx);
    endfunction

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    task automatic cyc;
        logic run;
        int cl;
        @(posedge clk);
        run      = ck_prev;
        ck_prev  = cke;
        last_run = run;
        cl       = int'(cas_lat);
        if (run) begin
            tk++;
            if (dqm) sm[(tk + 2) % 64] = 1'b1;
            if (rd_en) begin
                for (int j = 0; j < 16; j++) sv[(tk + cl + j) % 64] = 1'b0;
                for (int k = 0; k < (burst8 ? 8 : 4); k++) begin
                    sv[(tk + cl + k) % 64] = 1'b1;
                    sd[(tk + cl + k) % 64] = exp_word(mrow, exp_col(rd_col, burst8, burst_ilv, k), word_x32);
                end
            end else if (stop_en) begin
                for (int j = 0; j < 16; j++) sv[(tk + cl + j) % 64] = 1'b0;
            end
            if (act_en) mrow = act_row;
        end
        @(negedge clk);
        if (last_run) begin
            int s;
            s = tk % 64;
            chk(tag, "dout_vld", {31'd0, dout_vld}, {31'd0, sv[s]});
            chk(tag, "dout_oe", {31'd0, dout_oe}, {31'd0, sv[s] & ~sm[s]});
            if (sv[s]) chk(tag, "dout", dout, sd[s]);
            sv[s] = 1'b0;
            sm[s] = 1'b0;
        end else begin
            chk("R12", "frozen dout", dout, p_dout);
            chk("R12", "frozen vld/oe", {30'd0, dout_vld, dout_oe}, {30'd0, p_vld, p_oe});
        end
        p_dout = dout;
        p_vld  = dout_vld;
        p_oe   = dout_oe;
    endtask

    task automatic idle(int n);
        rd_en = 0; stop_en = 0; act_en = 0; dqm = 0;
        repeat (n) cyc();
    endtask

    task automatic rd(logic [8:0] col, logic x32, logic b8, logic il);
        rd_en = 1; rd_col = col; word_x32 = x32; burst8 = b8; burst_ilv = il;
        cyc();
        rd_en = 0;
    endtask

    task automatic act(logic [12:0] row);
        act_en = 1; act_row = row;
        cyc();
        act_en = 0;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) begin sv[i] = 0; sm[i] = 0; sd[i] = 0; end
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13", "reset dout", dout, 32'd0);
        chk("R13", "reset vld/oe", {30'd0, dout_vld, dout_oe}, 32'd0);
        rst_n = 1'b1;
        p_dout = dout; p_vld = dout_vld; p_oe = dout_oe;

        // R1 R2 R5: CL=3, burst of 4, sequential, wrap from offset 2
        tag = "R1"; cas_lat = 3'd3;
        act(13'h0ABC);
        rd(9'h006, 1'b1, 1'b0, 1'b0);
        tag = "R11"; idle(16);

        // R3: CL=4, interleaved burst of 8 from offset 5
        tag = "R3"; cas_lat = 3'd4;
        rd(9'h0A5, 1'b1, 1'b1, 1'b1);
        idle(16);

        // R4 R6: sequential burst of 8, x16 upper half, then x16 lower half
        tag = "R4"; cas_lat = 3'd3;
        act(13'h1F03);
        rd(9'h13D, 1'b0, 1'b1, 1'b0);
        idle(16);
        tag = "R6";
        rd(9'h02A, 1'b0, 1'b0, 1'b1);
        idle(16);

        // R7: word pin flips after the read
        tag = "R7";
        rd(9'h101, 1'b0, 1'b1, 1'b0);
        word_x32 = 1'b1; idle(2);
        word_x32 = 1'b0; idle(14);
        word_x32 = 1'b1;

        // R8: mask pulses during a burst, CL=5
        tag = "R8"; cas_lat = 3'd5;
        rd(9'h040, 1'b1, 1'b1, 1'b0);
        idle(3);
        dqm = 1; cyc(); dqm = 0; cyc(); dqm = 1; cyc(); cyc();
        idle(16);

        // R9: stop two cycles after the read
        tag = "R9";
        rd(9'h0F3, 1'b1, 1'b1, 1'b0);
        idle(1);
        stop_en = 1; cyc(); stop_en = 0;
        idle(16);

        // R10: second read interrupts the first
        tag = "R10"; cas_lat = 3'd4;
        rd(9'h010, 1'b1, 1'b1, 1'b0);
        idle(2);
        act(13'h0777);
        rd(9'h1C6, 1'b0, 1'b0, 1'b1);
        idle(16);

        // R12: freeze mid-burst, commands during freeze ignored
        tag = "R12"; cas_lat = 3'd3;
        rd(9'h088, 1'b1, 1'b1, 1'b1);
        idle(3);
        cke = 0; cyc();
        rd_en = 1; rd_col = 9'h033; dqm = 1; stop_en = 1;
        cyc(); cyc();
        rd_en = 0; dqm = 0; stop_en = 0; cke = 1;
        cyc();
        idle(16);

        // R10: random mix of reads, stops, activates, masks and freezes
        for (int b = 0; b < 4; b++) begin
            tag = "R10";
            cas_lat = 3'(3 + ($urandom % 4));
            for (int i = 0; i < 2000; i++) begin
                int r;
                r = int'($urandom % 100);
                rd_en     = (r < 22);
                stop_en   = (r >= 22 && r < 28);
                act_en    = (r >= 28 && r < 33);
                act_row   = 13'($urandom);
                rd_col    = 9'($urandom);
                word_x32  = 1'($urandom);
                burst8    = 1'($urandom);
                burst_ilv = 1'($urandom);
                dqm       = (($urandom % 100) < 10);
                cke       = (($urandom % 100) < 88);
                cyc();
            end
            cke = 1;
            idle(24);
        end

        summary();
        $finish;
    end

endmodule